// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block sits on the controller side of a DDR SDRAM interface. From reset it drives the memory command pins (clock enable, chip select, the three strobes, bank address and a 12-bit address) through the fixed power-up order the memory needs. It first waits with clock enable low. It then precharges, enables the DLL through the extended mode register and loads the mode register with a DLL reset. After a second precharge it issues two refreshes. It ends with a mode load that clears the DLL reset. Between steps it inserts the wait each step needs, as NOP cycles.

Every wait is a parameter counted in clock cycles. The waits are the stabilization time with clock enable low, the precharge, mode-load and refresh recovery times, and the lock time the DLL needs after its reset. When the sequence is over and the DLL lock time has also run out, `init_done` goes high and stays high. The normal command scheduler takes over at that point. A synchronous reset restarts the whole bring-up.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high, and for T_STAB cycles after it is released, `cke` is 0, `init_done` is 0 and the bus carries NOP.
- R2: In the cycle after the stabilization wait, `cke` goes to 1 with a NOP. In the cycle after that comes Precharge All, with `addr[10]` = 1 and every other address bit and both bank bits 0. `cke` then stays 1 until the next reset.
- R3: Each command after the first precharge comes exactly G cycles after the one before it, with NOP on every cycle in between. G is max(T,2), where T is the recovery parameter of the earlier command: T_RP after a precharge, T_MRD after a mode load, T_RFC after a refresh.
- R4: The first mode load addresses the extended mode register (`ba` = 2'b01) with `addr` = 0, which enables the DLL.
- R5: The next mode load has `ba` = 2'b00. Its address carries, by bit: [2:0] burst length code (BURST_LEN_CODE), [3] burst type (BURST_INTERLEAVE), [6:4] = 3'b011 for CAS latency 3, [7] = 0, [8] = 1 for DLL reset, [11:9] = 0.
- R6: After it come a Precharge All, then two Auto Refresh commands spaced per R3. During refresh, `ba` and `addr` are 0.
- R7: The final command is a mode load with `ba` = 2'b00 and the same word as R5, except that bit 8 is 0.
- R8: `init_done` rises in cycle max(F+G_MRD, D+T_DLL)+1. F is the cycle of the final mode load, D is the cycle of the DLL-reset load and G_MRD = max(T_MRD,2). After that it stays 1, with `cke` = 1 and NOP, until reset.
- R9: Asserting `rst` at any point returns the block within one cycle to the R1 state. The full sequence then starts again from the beginning.
- R10: Pin encodings (`cs_n`,`ras_n`,`cas_n`,`we_n`) are: NOP 0111, Precharge 0010, Auto Refresh 0001, Mode Load 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / mode register select |
| addr | output | 12 | Address / mode word |
| init_done | output | 1 | High once the memory may take normal commands |

## Verification
The bound checker watches, on every cycle, the properties that hold whatever the parameters are. While `cke` is low only NOP appears. Every command is followed by a NOP. Precharge always has A10 set. Mode loads carry legal bank bits and a fixed CAS latency field. `init_done` never falls outside reset and never rises before the DLL lock time has run since the DLL reset. Only the bench's cycle-exact reference model can show the exact order of commands, the precise gap lengths, the mode word contents and the cycle in which `init_done` rises. It runs two parameter sets, one where the DLL wait sets the finish and one with clamped minimum gaps, across a full run and a reset in mid-sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [4:0] {
        ST_STAB, ST_CKE_UP,
        ST_PALL1, ST_W_RP1,
        ST_EMR, ST_W_MRD1,
        ST_MRS_RST, ST_W_MRD2,
        ST_PALL2, ST_W_RP2,
        ST_REF1, ST_W_RFC1,
        ST_REF2, ST_W_RFC2,
        ST_MRS_CLR, ST_W_MRD3,
        ST_DLL_WAIT, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NOP, OP_PRE_ALL, OP_REFRESH, OP_MODE
    } mem_op_e;

    typedef struct packed {
        logic        cke;
        logic        cs_n;
        logic        ras_n;
        logic        cas_n;
        logic        we_n;
        logic [1:0]  ba;
        logic [11:0] addr;
    } mem_pins_t;

    localparam logic [1:0]  BA_MODE     = 2'b00;
    localparam logic [1:0]  BA_EXT_MODE = 2'b01;
    localparam logic [11:0] ADDR_A10    = 12'h400;
    localparam logic [2:0]  CAS_LAT_3   = 3'b011;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Shortest legal spacing between two commands.
    function automatic int unsigned gap_of(input int unsigned t);
        return max2(t, 2);
    endfunction

    function automatic logic [11:0] mode_word(input logic [2:0] bl_code,
                                              input logic       interleave,
                                              input logic       dll_reset);
        return {3'b000, dll_reset, 1'b0, CAS_LAT_3, interleave, bl_code};
    endfunction

endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
    parameter int unsigned   W       = 8,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
(
    input  logic        cke_on,
    input  mem_op_e     op,
    input  logic [1:0]  ba_in,
    input  logic [11:0] addr_in,
    output mem_pins_t   pins
);
    always_comb begin
        pins.cke  = cke_on;
        pins.ba   = ba_in;
        pins.addr = addr_in;
        unique case (op)
            OP_PRE_ALL: {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0010;
            OP_REFRESH: {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0001;
            OP_MODE:    {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0000;
            default:    {pins.cs_n, pins.ras_n, pins.cas_n, pins.we_n} = 4'b0111;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned T_STAB           = 25000,
    parameter int unsigned T_RP             = 3,
    parameter int unsigned T_MRD            = 2,
    parameter int unsigned T_RFC            = 10,
    parameter int unsigned T_DLL            = 200,
    parameter logic [2:0]  BURST_LEN_CODE   = 3'b011,
    parameter logic        BURST_INTERLEAVE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr,
    output logic        init_done
);
    localparam int unsigned STAB_C  = max2(T_STAB, 1);
    localparam int unsigned DLL_C   = max2(T_DLL, 1);
    localparam int unsigned CNT_MAX = max2(max2(STAB_C, gap_of(T_RP)),
                                           max2(gap_of(T_MRD), gap_of(T_RFC)));
    localparam int unsigned WAIT_W  = $clog2(CNT_MAX + 1);
    localparam int unsigned DLL_W   = $clog2(DLL_C + 1);

    localparam logic [WAIT_W-1:0] LD_STAB = WAIT_W'(STAB_C - 1);
    localparam logic [WAIT_W-1:0] LD_RP   = WAIT_W'(gap_of(T_RP) - 2);
    localparam logic [WAIT_W-1:0] LD_MRD  = WAIT_W'(gap_of(T_MRD) - 2);
    localparam logic [WAIT_W-1:0] LD_RFC  = WAIT_W'(gap_of(T_RFC) - 2);
    localparam logic [DLL_W-1:0]  LD_DLL  = DLL_W'(DLL_C - 1);

    localparam logic [11:0] MODE_RST = mode_word(BURST_LEN_CODE, BURST_INTERLEAVE, 1'b1);
    localparam logic [11:0] MODE_CLR = mode_word(BURST_LEN_CODE, BURST_INTERLEAVE, 1'b0);

    seq_state_e        st, st_nxt;
    logic              wait_load, wait_zero;
    logic [WAIT_W-1:0] wait_val;
    logic              dll_load, dll_zero;
    logic              cke_on;
    mem_op_e           op;
    logic [1:0]        ba_sel;
    logic [11:0]       addr_sel;
    mem_pins_t         pins;

    ddr_init_cnt #(.W(WAIT_W), .RST_VAL(LD_STAB)) u_wait_cnt (
        .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val), .zero(wait_zero)
    );

    ddr_init_cnt #(.W(DLL_W), .RST_VAL(LD_DLL)) u_dll_cnt (
        .clk(clk), .rst(rst), .load(dll_load), .load_val(LD_DLL), .zero(dll_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) st <= ST_STAB;
        else     st <= st_nxt;
    end

    always_comb begin
        st_nxt    = st;
        wait_load = 1'b0;
        wait_val  = '0;
        dll_load  = 1'b0;
        cke_on    = 1'b1;
        op        = OP_NOP;
        ba_sel    = '0;
        addr_sel  = '0;
        unique case (st)
            ST_STAB: begin
                cke_on = 1'b0;
                if (wait_zero) st_nxt = ST_CKE_UP;
            end
            ST_CKE_UP:   st_nxt = ST_PALL1;
            ST_PALL1: begin
                op = OP_PRE_ALL; addr_sel = ADDR_A10;
                wait_load = 1'b1; wait_val = LD_RP; st_nxt = ST_W_RP1;
            end
            ST_W_RP1:    if (wait_zero) st_nxt = ST_EMR;
            ST_EMR: begin
                op = OP_MODE; ba_sel = BA_EXT_MODE;
                wait_load = 1'b1; wait_val = LD_MRD; st_nxt = ST_W_MRD1;
            end
            ST_W_MRD1:   if (wait_zero) st_nxt = ST_MRS_RST;
            ST_MRS_RST: begin
                op = OP_MODE; ba_sel = BA_MODE; addr_sel = MODE_RST;
                dll_load = 1'b1;
                wait_load = 1'b1; wait_val = LD_MRD; st_nxt = ST_W_MRD2;
            end
            ST_W_MRD2:   if (wait_zero) st_nxt = ST_PALL2;
            ST_PALL2: begin
                op = OP_PRE_ALL; addr_sel = ADDR_A10;
                wait_load = 1'b1; wait_val = LD_RP; st_nxt = ST_W_RP2;
            end
            ST_W_RP2:    if (wait_zero) st_nxt = ST_REF1;
            ST_REF1: begin
                op = OP_REFRESH;
                wait_load = 1'b1; wait_val = LD_RFC; st_nxt = ST_W_RFC1;
            end
            ST_W_RFC1:   if (wait_zero) st_nxt = ST_REF2;
            ST_REF2: begin
                op = OP_REFRESH;
                wait_load = 1'b1; wait_val = LD_RFC; st_nxt = ST_W_RFC2;
            end
            ST_W_RFC2:   if (wait_zero) st_nxt = ST_MRS_CLR;
            ST_MRS_CLR: begin
                op = OP_MODE; ba_sel = BA_MODE; addr_sel = MODE_CLR;
                wait_load = 1'b1; wait_val = LD_MRD; st_nxt = ST_W_MRD3;
            end
            ST_W_MRD3:   if (wait_zero) st_nxt = ST_DLL_WAIT;
            ST_DLL_WAIT: if (dll_zero) st_nxt = ST_DONE;
            ST_DONE:     st_nxt = ST_DONE;
            default:     st_nxt = ST_STAB;
        endcase
    end

    ddr_init_cmd_enc u_enc (
        .cke_on(cke_on), .op(op), .ba_in(ba_sel), .addr_in(addr_sel), .pins(pins)
    );

    assign cke       = pins.cke;
    assign cs_n      = pins.cs_n;
    assign ras_n     = pins.ras_n;
    assign cas_n     = pins.cas_n;
    assign we_n      = pins.we_n;
    assign ba        = pins.ba;
    assign addr      = pins.addr;
    assign init_done = (st == ST_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int unsigned T_DLL = 200
) (
    input logic        clk,
    input logic        rst,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [11:0] addr,
    input logic        init_done
);
    logic is_nop, is_pre, is_mode, is_cmd;
    assign is_nop  = {cs_n, ras_n, cas_n, we_n} == 4'b0111;
    assign is_pre  = {cs_n, ras_n, cas_n, we_n} == 4'b0010;
    assign is_mode = {cs_n, ras_n, cas_n, we_n} == 4'b0000;
    assign is_cmd  = !cs_n && !is_nop;

    int unsigned since_dll;
    logic        dll_seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_dll <= 0;
            dll_seen  <= 1'b0;
        end else if (is_mode && ba == 2'b00 && addr[8]) begin
            since_dll <= 0;
            dll_seen  <= 1'b1;
        end else if (since_dll < T_DLL) begin
            since_dll <= since_dll + 1;
        end
    end

    AST_CKE_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cke |-> is_nop);                                               // R1
    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);                                                   // R2
    AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
        is_cmd |=> is_nop);                                             // R3
    AST_EXT_MODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (is_mode && ba == 2'b01) |-> addr == 12'h000);                  // R4
    AST_MODE_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (is_mode && ba == 2'b00) |-> (addr[6:4] == 3'b011 && addr[11:9] == 3'b000 && !addr[7])); // R5
    AST_MODE_BANK: assert property (@(posedge clk) disable iff (rst)
        is_mode |-> ba[1] == 1'b0);                                     // R5
    AST_PRE_ALL_A10: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> addr[10]);                                           // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);                                       // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cke && is_nop));                                 // R8
    AST_DONE_AFTER_DLL: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (dll_seen && since_dll >= T_DLL));         // R8
    AST_RESET_RETURN: assert property (@(posedge clk)
        rst |=> (!cke && !init_done));                                  // R9
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.T_DLL(T_DLL)) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic [1:0]  ba_a;
    logic [11:0] addr_a;
    logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]  ba_b;
    logic [11:0] addr_b;

    // Set A: DLL lock time sets the finish.
    ddr_init_seq #(.T_STAB(20), .T_RP(3), .T_MRD(2), .T_RFC(7), .T_DLL(60),
                   .BURST_LEN_CODE(3'b010), .BURST_INTERLEAVE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a),
        .we_n(we_a), .ba(ba_a), .addr(addr_a), .init_done(done_a));

    // Set B: short gaps clamped to two cycles, DLL wait already expired.
    ddr_init_seq #(.T_STAB(5), .T_RP(1), .T_MRD(1), .T_RFC(3), .T_DLL(2),
                   .BURST_LEN_CODE(3'b001), .BURST_INTERLEAVE(1'b0)) u_dut2 (
        .clk(clk), .rst(rst), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b),
        .we_n(we_b), .ba(ba_b), .addr(addr_b), .init_done(done_b));

    int vectors = 0;
    int errors  = 0;

    function automatic int g(input int t);
        return (t < 2) ? 2 : t;
    endfunction

    // Expected pins {cke, cs,ras,cas,we, ba, addr, done} at cycle n after reset release.
    function automatic logic [19:0] model(input int n, input int stab, input int rp,
                                          input int mrd, input int rfc, input int dll,
                                          input logic [11:0] mode, output string tag);
        int c0, c1, c2, c3, c4, c5, c6, d;
        logic [19:0] nop_hi;
        nop_hi = {1'b1, 4'b0111, 2'b00, 12'h000, 1'b0};
        c0 = stab + 1;
        c1 = c0 + g(rp);
        c2 = c1 + g(mrd);
        c3 = c2 + g(mrd);
        c4 = c3 + g(rp);
        c5 = c4 + g(rfc);
        c6 = c5 + g(rfc);
        d  = ((c6 + g(mrd)) > (c2 + dll) ? (c6 + g(mrd)) : (c2 + dll)) + 1;
        tag = "R3";
        if (n < stab)        begin tag = "R1"; return {1'b0, 4'b0111, 2'b00, 12'h000, 1'b0}; end
        if (n == stab)       begin tag = "R2"; return nop_hi; end
        if (n == c0)         begin tag = "R2"; return {1'b1, 4'b0010, 2'b00, 12'h400, 1'b0}; end
        if (n == c1)         begin tag = "R4"; return {1'b1, 4'b0000, 2'b01, 12'h000, 1'b0}; end
        if (n == c2)         begin tag = "R5"; return {1'b1, 4'b0000, 2'b00, mode | 12'h100, 1'b0}; end
        if (n == c3)         begin tag = "R6"; return {1'b1, 4'b0010, 2'b00, 12'h400, 1'b0}; end
        if (n == c4 || n == c5) begin tag = "R6"; return {1'b1, 4'b0001, 2'b00, 12'h000, 1'b0}; end
        if (n == c6)         begin tag = "R7"; return {1'b1, 4'b0000, 2'b00, mode, 1'b0}; end
        if (n >= d)          begin tag = "R8"; return {nop_hi[19:1], 1'b1}; end
        if (n > c6) tag = "R8";
        return nop_hi;
    endfunction

    task automatic compare(input int n, input string force_tag);
        logic [19:0] exp_a, exp_b, act_a, act_b;
        string ta, tb_;
        exp_a = model(n, 20, 3, 2, 7, 60, 12'h03A, ta);
        exp_b = model(n, 5, 1, 1, 3, 2, 12'h031, tb_);
        if (force_tag != "") begin ta = force_tag; tb_ = force_tag; end
        act_a = {cke_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a, done_a};
        act_b = {cke_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b, done_b};
        vectors += 2;
        if (act_a !== exp_a) begin
            errors++;
            $display("FAIL %s set A cycle %0d: actual %h expected %h (R10 encoding applies)", ta, n, act_a, exp_a);
        end
        if (act_b !== exp_b) begin
            errors++;
            $display("FAIL %s set B cycle %0d: actual %h expected %h (R10 encoding applies)", tb_, n, act_b, exp_b);
        end
    endtask

    task automatic step_cmp(input int n, input string force_tag);
        @(posedge clk);
        @(negedge clk);
        compare(n, force_tag);
    endtask

    initial begin
        // R1 / R9: reset state held for several cycles
        rst = 1'b1;
        for (int k = 0; k < 3; k++) step_cmp(0, "R1");
        rst = 1'b0;
        compare(0, "");
        // Full sequence on both parameter sets, R2..R8 and R10
        for (int k = 1; k <= 120; k++) step_cmp(k, "");
        // R9: reset in the middle of the sequence
        rst = 1'b1;
        step_cmp(0, "R9");
        rst = 1'b0;
        compare(0, "R9");
        for (int k = 1; k <= 30; k++) step_cmp(k, "");
        rst = 1'b1;
        step_cmp(0, "R9");
        step_cmp(0, "R9");
        rst = 1'b0;
        compare(0, "R9");
        for (int k = 1; k <= 120; k++) step_cmp(k, "");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule